// File: doc/BRIEF.md
# Compare-Match Timer / Pulse Counter

This block holds a 16-bit up-counter behind four word-aligned registers on a simple single-cycle read/write bus. In time mode the counter advances on a one-cycle tick strobe from an external prescaler. In pulse mode it advances on a chosen edge of one of four external inputs, which already share the block's clock. When the counter equals the programmed compare value and an advance occurs, a sticky match flag is set. The flag drives an interrupt when interrupts are enabled, and a hardware trigger output asserts as well. The prescale register is only stored and handed on to the prescaler block.

The core is a three-state machine. `ST_OFF` is the disabled state, in which the counter, the flag and the trigger are held at zero. `ST_ARMED` is the counting state with the trigger low. `ST_FIRED` is the counting state with the trigger high. The transitions are:
- enable (OFF to ARMED, or OFF to FIRED when the first advance is already a match)
- match (ARMED to FIRED)
- release (FIRED to ARMED, taken on the next advance that is not a match, and only when the compare value is non-zero)
- disable (any state to OFF when the enable bit is 0)

Word offsets: 0x0 control/status, 0x4 prescale, 0x8 compare, 0xC counter. Control/status layout: bit 0 enable, bit 1 mode (0 time, 1 pulse), bit 2 free-running, bit 3 polarity (0 rising, 1 falling), bits [5:4] pulse input select, bit 6 interrupt enable, bit 7 match flag.

Top module: `cmt_timer`

## Requirements
- R1: After reset, every register reads 0, and `irq_o`, `trig_o` and `psc_cfg_o` are 0.
- R2: Registers decode at word offsets 0x0/0x4/0x8/0xC. Control bits [31:8], prescale bits above bit 6, and compare and counter bits [31:16] read as 0.
- R3: While the enable bit is 0, the counter reads 0, the flag is 0, the trigger is 0, and advance events have no effect.
- R4: With free-running = 0, an advance while counter == compare sets the flag and returns the counter to 0. Any other advance adds 1.
- R5: With free-running = 1, an advance at counter == compare sets the flag and the counter keeps adding 1.
- R6: Writing control with bit 7 = 1 clears the flag, and writing bit 7 = 0 leaves it unchanged. If a match and a clearing write fall in the same cycle, the flag ends at 1.
- R7: `irq_o` is 1 exactly while the interrupt enable bit and the flag are both 1.
- R8: `trig_o` rises with a match and falls on the next advance. With compare = 0 it stays high until the timer is disabled.
- R9: In pulse mode, the input chosen by bits [5:4] is compared against its value in the previous cycle. Polarity 0 counts 0-to-1 changes and polarity 1 counts 1-to-0 changes. Unselected inputs are ignored.
- R10: In time mode, each cycle with `tick_i` = 1 is one advance, and the pulse inputs are ignored.
- R11: Control bits [5:1] and the prescale register are written only when enable is 0 both before and in the write. Otherwise those bits keep their old values. The enable and interrupt enable bits are always writable.
- R12: Writes to the counter offset do nothing, and the compare register may be rewritten while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits [3:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| tick_i | input | 1 | Prescaler strobe for time mode |
| pulse_i | input | 4 | External pulse inputs |
| psc_cfg_o | output | 7 | Stored prescale setting |
| irq_o | output | 1 | Interrupt request |
| trig_o | output | 1 | Hardware trigger |

## Verification
The bench targets four kinds of corner case:
- The advance that lands exactly on the compare value. An off-by-one design would report a period of compare instead of compare+1, or would miss the reload.
- A compare value of zero. A design that treats zero like any other value would drop the trigger on the next advance.
- A flag clear that arrives in the same cycle as a match. A design with the wrong priority would lose the event.
- Writes that try to change configuration while running, including in the write that turns the timer on. A design without the lock would switch modes or edge sense mid-count. Falling-edge counting on held inputs and pulses on unselected inputs expose edge detection that looks at the wrong level or the wrong input.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRED = 2'd2
    } core_state_t;

    // word index = byte address bits [3:2]
    localparam logic [1:0] IDX_CTRL = 2'd0;
    localparam logic [1:0] IDX_PSC  = 2'd1;
    localparam logic [1:0] IDX_CMP  = 2'd2;
    localparam logic [1:0] IDX_CNT  = 2'd3;

    // control/status bit positions
    localparam int B_EN   = 0;
    localparam int B_MODE = 1;
    localparam int B_FRUN = 2;
    localparam int B_POL  = 3;
    localparam int B_SEL  = 4;
    localparam int B_IE   = 6;
    localparam int B_FLAG = 7;

    typedef struct packed {
        logic [1:0] sel;
        logic       pol;
        logic       frun;
        logic       mode;
    } cfg_t;

endpackage

// File: rtl/cmt_regs.sv
module cmt_regs
    import cmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              flag,
    output logic              en,
    output logic              ie,
    output cfg_t              cfg,
    output logic [CNT_W-1:0]  cmp,
    output logic [PSC_W-1:0]  psc,
    output logic              flag_clr
);

    localparam int CTRL_W = B_FLAG + 1;

    logic [1:0] idx;
    logic       wr_ctrl, wr_psc, wr_cmp;
    logic       cfg_open;
    logic       unused_bits;

    assign idx      = bus_addr[3:2];
    assign wr_ctrl  = bus_sel && bus_wr && (idx == IDX_CTRL);
    assign wr_psc   = bus_sel && bus_wr && (idx == IDX_PSC);
    assign wr_cmp   = bus_sel && bus_wr && (idx == IDX_CMP);
    assign cfg_open = !en && !bus_wdata[B_EN];
    assign flag_clr = wr_ctrl && bus_wdata[B_FLAG];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:CNT_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en  <= 1'b0;
            ie  <= 1'b0;
            cfg <= '0;
            cmp <= '0;
            psc <= '0;
        end else begin
            if (wr_ctrl) begin
                en <= bus_wdata[B_EN];
                ie <= bus_wdata[B_IE];
                if (cfg_open) begin
                    cfg.mode <= bus_wdata[B_MODE];
                    cfg.frun <= bus_wdata[B_FRUN];
                    cfg.pol  <= bus_wdata[B_POL];
                    cfg.sel  <= bus_wdata[B_SEL +: 2];
                end
            end
            if (wr_psc && !en) begin
                psc <= bus_wdata[PSC_W-1:0];
            end
            if (wr_cmp) begin
                cmp <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            IDX_CTRL: bus_rdata[CTRL_W-1:0] = {flag, ie, cfg.sel, cfg.pol,
                                               cfg.frun, cfg.mode, en};
            IDX_PSC:  bus_rdata[PSC_W-1:0]  = psc;
            IDX_CMP:  bus_rdata[CNT_W-1:0]  = cmp;
            IDX_CNT:  bus_rdata[CNT_W-1:0]  = cnt;
            default:  bus_rdata = '0;
        endcase
    end

    // R11: configuration frozen while running
    p_cfg_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(cfg));
    p_psc_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(psc));

endmodule

// File: rtl/cmt_event.sv
module cmt_event #(
    parameter int N_IN  = 4,
    parameter int SEL_W = $clog2(N_IN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [N_IN-1:0]  pin,
    input  logic             mode,
    input  logic             pol,
    input  logic [SEL_W-1:0] sel,
    output logic             evt
);

    logic [N_IN-1:0] pin_q;
    logic [N_IN-1:0] rise, fall;

    // previous-cycle copy, tracked even in reset so no edge is invented
    always_ff @(posedge clk) begin
        pin_q <= pin;
    end

    genvar g;
    generate
        for (g = 0; g < N_IN; g++) begin : g_lane
            assign rise[g] = pin[g] && !pin_q[g];
            assign fall[g] = !pin[g] && pin_q[g];
        end
    endgenerate

    always_comb begin
        if (mode) evt = pol ? fall[sel] : rise[sel];
        else      evt = tick;
    end

    // R9: rising-edge sense reacts only to a 0-to-1 change of the chosen input
    p_rise_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !pol && evt) |-> (pin[sel] && !$past(pin[sel])));
    p_fall_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && pol && evt) |-> (!pin[sel] && $past(pin[sel])));

endmodule

// File: rtl/cmt_core.sv
module cmt_core
    import cmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             frun,
    input  logic             evt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             trig
);

    core_state_t st_q, st_nxt;
    logic        adv, hit;

    assign adv = en && evt;
    assign hit = adv && (cnt == cmp);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_nxt;
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_OFF: begin
                if (en) st_nxt = hit ? ST_FIRED : ST_ARMED;
            end
            ST_ARMED: begin
                if (!en)     st_nxt = ST_OFF;
                else if (hit) st_nxt = ST_FIRED;
            end
            ST_FIRED: begin
                if (!en)                              st_nxt = ST_OFF;
                else if (adv && !hit && (cmp != '0))  st_nxt = ST_ARMED;
            end
            default: st_nxt = ST_OFF;
        endcase
    end

    // outputs: counter and sticky flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else if (!en) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else begin
            if (adv) begin
                if (hit && !frun) cnt <= '0;
                else              cnt <= cnt + 1'b1;
            end
            if (hit)           flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end

    always_comb begin
        trig = (st_q == ST_FIRED);
    end

    p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0 && !flag && !trig));
    p_flag_on_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(en && evt && (cnt == cmp)));
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && evt && !frun && (cnt == cmp)) |=> (cnt == '0));
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && flag_clr && en && !(evt && (cnt == cmp))) |=> !flag);
    p_zero_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && en && (cmp == '0)) |=> trig);

endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 7,
    parameter int N_IN   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_i,
    input  logic [N_IN-1:0]   pulse_i,
    output logic [PSC_W-1:0]  psc_cfg_o,
    output logic              irq_o,
    output logic              trig_o
);

    logic             en, ie, flag, flag_clr, evt;
    cfg_t             cfg;
    logic [CNT_W-1:0] cmp, cnt;

    cmt_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PSC_W(PSC_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt(cnt), .flag(flag),
        .en(en), .ie(ie), .cfg(cfg), .cmp(cmp), .psc(psc_cfg_o),
        .flag_clr(flag_clr)
    );

    cmt_event #(.N_IN(N_IN)) u_event (
        .clk(clk), .rst_n(rst_n), .tick(tick_i), .pin(pulse_i),
        .mode(cfg.mode), .pol(cfg.pol), .sel(cfg.sel), .evt(evt)
    );

    cmt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en), .frun(cfg.frun), .evt(evt),
        .cmp(cmp), .flag_clr(flag_clr), .cnt(cnt), .flag(flag),
        .trig(trig_o)
    );

    assign irq_o = ie && flag;

    // R7: no interrupt without a pending flag
    p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (bus_rdata !== 'x) && flag);

endmodule

// File: tb/tb_cmt_timer.sv
module tb_cmt_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        tick_i = 1'b0;
    logic [3:0]  pulse_i = '0;
    logic [6:0]  psc_cfg_o;
    logic        irq_o, trig_o;

    int checks = 0, errors = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmt_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_i(tick_i), .pulse_i(pulse_i), .psc_cfg_o(psc_cfg_o),
        .irq_o(irq_o), .trig_o(trig_o)
    );

    typedef struct packed {
        logic        mode;
        logic        pol;
        logic [1:0]  sel;
        logic [1:0]  lane;
        logic        frun;
        logic [15:0] cmp;
        logic [7:0]  n;
        logic [15:0] ecnt;
        logic        eflag;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,2'd0,2'd0,1'b0,16'd5,8'd3,16'd3,1'b0},
        '{1'b0,1'b0,2'd0,2'd0,1'b0,16'd5,8'd6,16'd0,1'b1},
        '{1'b0,1'b0,2'd0,2'd0,1'b0,16'd5,8'd8,16'd2,1'b1},
        '{1'b0,1'b0,2'd0,2'd0,1'b1,16'd5,8'd8,16'd8,1'b1},
        '{1'b0,1'b0,2'd0,2'd0,1'b1,16'd2,8'd2,16'd2,1'b0},
        '{1'b0,1'b0,2'd0,2'd0,1'b0,16'd0,8'd4,16'd0,1'b1},
        '{1'b1,1'b0,2'd2,2'd2,1'b0,16'd3,8'd3,16'd3,1'b0},
        '{1'b1,1'b0,2'd1,2'd1,1'b0,16'd3,8'd5,16'd1,1'b1},
        '{1'b1,1'b1,2'd3,2'd3,1'b1,16'd1,8'd4,16'd4,1'b1},
        '{1'b1,1'b0,2'd0,2'd2,1'b0,16'd3,8'd4,16'd0,1'b0},
        '{1'b1,1'b1,2'd2,2'd1,1'b0,16'd9,8'd2,16'd0,1'b0}
    };

    function automatic logic [31:0] mk_ctrl(input logic en, mode, frun, pol,
                                            input logic [1:0] sel, input logic ie);
        return {24'd0, 1'b0, ie, sel, pol, frun, mode, en};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic pulses(input logic [1:0] lane, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pulse_i[lane] = 1'b1;
            @(negedge clk); pulse_i[lane] = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic start(input logic mode, frun, pol, input logic [1:0] sel,
                         input logic ie, input logic [15:0] cmp);
        bus_write(4'h0, 32'd0);
        bus_write(4'h8, {16'd0, cmp});
        bus_write(4'h0, mk_ctrl(1'b0, mode, frun, pol, sel, ie));
        bus_write(4'h0, mk_ctrl(1'b1, mode, frun, pol, sel, ie));
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        for (int a = 0; a < 4; a++) begin
            bus_read(4'(a * 4), rd);
            chk("R1 register reset", rd, 32'd0);
        end
        chk("R1 irq/trig/psc reset", {irq_o, trig_o, psc_cfg_o}, 9'd0);

        // vector table: R4 R5 R9 R10
        for (int v = 0; v < NV; v++) begin
            start(VECS[v].mode, VECS[v].frun, VECS[v].pol, VECS[v].sel, 1'b0, VECS[v].cmp);
            if (VECS[v].mode) pulses(VECS[v].lane, int'(VECS[v].n));
            else              ticks(int'(VECS[v].n));
            bus_read(4'hC, rd);
            chk(VECS[v].mode ? "R9 pulse count" : (VECS[v].frun ? "R5 free count" : "R4 reload count"),
                rd, {16'd0, VECS[v].ecnt});
            bus_read(4'h0, rd);
            chk(VECS[v].frun ? "R5 flag" : "R4 flag", {31'd0, rd[7]}, {31'd0, VECS[v].eflag});
        end

        // R9 falling-edge sense: held-high input counts only on release
        start(1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 16'd100);
        @(negedge clk); pulse_i[0] = 1'b1;
        @(negedge clk);
        bus_read(4'hC, rd);
        chk("R9 falling sense ignores rise", rd, 32'd0);
        pulse_i[0] = 1'b0;
        @(negedge clk);
        bus_read(4'hC, rd);
        chk("R9 falling sense counts fall", rd, 32'd1);

        // R10 time mode ignores pulse inputs
        start(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 16'd100);
        pulses(2'd0, 3);
        bus_read(4'hC, rd);
        chk("R10 pins ignored in time mode", rd, 32'd0);
        ticks(2);
        bus_read(4'hC, rd);
        chk("R10 ticks counted", rd, 32'd2);

        // R8 trigger window, compare = 2
        start(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 16'd2);
        ticks(2);
        chk("R8 no trigger before match", {31'd0, trig_o}, 32'd0);
        ticks(1);
        chk("R8 trigger on match", {31'd0, trig_o}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R8 trigger holds between advances", {31'd0, trig_o}, 32'd1);
        ticks(1);
        chk("R8 trigger falls on next advance", {31'd0, trig_o}, 32'd0);

        // R8 compare = 0 holds until disable; R3 disable clears
        start(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 16'd0);
        ticks(4);
        chk("R8 zero compare holds trigger", {31'd0, trig_o}, 32'd1);
        bus_write(4'h0, 32'd0);
        @(negedge clk);
        chk("R8 trigger cleared by disable", {31'd0, trig_o}, 32'd0);
        ticks(3);
        bus_read(4'hC, rd);
        chk("R3 disabled counter stays 0", rd, 32'd0);
        bus_read(4'h0, rd);
        chk("R3 disabled flag 0", {31'd0, rd[7]}, 32'd0);

        // R6 / R7 flag handling, compare = 1, interrupt enabled
        start(1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 16'd1);
        chk("R7 irq low without flag", {31'd0, irq_o}, 32'd0);
        ticks(2);
        chk("R7 irq with flag", {31'd0, irq_o}, 32'd1);
        bus_write(4'h0, mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1));
        bus_read(4'h0, rd);
        chk("R6 writing 0 keeps flag", {31'd0, rd[7]}, 32'd1);
        bus_write(4'h0, mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1) | 32'h80);
        bus_read(4'h0, rd);
        chk("R6 write-one clears flag", {31'd0, rd[7]}, 32'd0);
        chk("R7 irq drops with flag", {31'd0, irq_o}, 32'd0);
        bus_write(4'h0, mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0));
        chk("R7 irq masked", {31'd0, irq_o}, 32'd0);
        ticks(1);
        @(negedge clk);
        tick_i = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h0;
        bus_wdata = mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0) | 32'h80;
        @(negedge clk);
        tick_i = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(4'h0, rd);
        chk("R6 match beats clear", {31'd0, rd[7]}, 32'd1);

        // R11 locked configuration, R12 counter/compare writes
        start(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 16'd50);
        bus_write(4'h0, mk_ctrl(1'b1, 1'b1, 1'b1, 1'b1, 2'd3, 1'b0));
        bus_read(4'h0, rd);
        chk("R11 fields locked while enabled", rd & 32'h3E, 32'd0);
        bus_write(4'h4, 32'h55);
        chk("R11 prescale locked while enabled", {25'd0, psc_cfg_o}, 32'd0);
        ticks(3);
        bus_write(4'hC, 32'h1234);
        bus_read(4'hC, rd);
        chk("R12 counter write ignored", rd, 32'd3);
        bus_write(4'h8, 32'd7);
        bus_read(4'h8, rd);
        chk("R12 compare writable while enabled", rd, 32'd7);
        bus_write(4'h0, 32'd0);
        bus_write(4'h0, mk_ctrl(1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0));
        bus_read(4'h0, rd);
        chk("R11 enabling write keeps fields", rd, 32'h1);
        bus_write(4'h0, 32'd0);
        bus_write(4'h4, 32'hFFFF_FF55);
        chk("R11 prescale written while disabled", {25'd0, psc_cfg_o}, 32'h55);

        // R2 decode and read-as-zero bits
        bus_read(4'h4, rd);
        chk("R2 prescale readback", rd, 32'h55);
        bus_write(4'h0, 32'hFFFF_FF7E);
        bus_read(4'h0, rd);
        chk("R2 control upper bits zero", rd, 32'h7E);
        bus_write(4'h8, 32'hABCD_1234);
        bus_read(4'h8, rd);
        chk("R2 compare upper bits zero", rd, 32'h1234);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule